// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a four-wire serial memory. The pins for chip select, serial clock, serial data in and serial data out are sampled in the system clock domain. Each transaction opens with an eight-bit instruction. That instruction selects one of six actions: set the write-enable latch, clear it, read the status byte, write the status byte, read the memory, or write the memory. The memory is a byte-addressed array of 8192 bytes. Reads stream forward from a two-byte start address for as long as chip select stays low.

A memory write does not touch the array while the host is still clocking. The data bytes are staged in a 64-byte page buffer. They are committed only when chip select rises after a complete, well-formed write sequence. That rising edge starts a self-timed internal write cycle, whose length is a cycle count set by a parameter. While that cycle runs, the busy flag is set, and the only instruction the block answers is the status read.

Hold gating and write protection are decided by neighbouring blocks. Each reaches this block through a plain enable input. The block exports its stored protection field, so the protection logic can read it.

Top module: `spi_ee_core`

## Requirements
- R1: Serial clock idle-low and idle-high framing both work: SI is taken on each rising SCK edge, and SO changes only after a falling SCK edge.
- R2: Instruction 0x06 sets the write-enable latch and 0x04 clears it.
- R3: Instruction 0x05 returns the status byte repeatedly while chip select stays low. The byte is laid out as: bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = stored protection bits, bit 7 = stored protect-enable bit, all other bits 0.
- R4: Instruction 0x03 takes two address bytes, high byte first. The top 3 bits of the high byte are ignored. The block then returns the byte at that address and increments the address after every byte, wrapping from 0x1FFF to 0x0000.
- R5: Instruction 0x02 takes two address bytes and then data bytes. The data is staged, and the array changes only after chip select rises following at least one whole data byte. The low 6 address bits step and wrap inside the 64-byte page. Bytes of the page that were not written keep their old value. The internal write cycle starts on that rising edge.
- R6: After a commit, status bit 0 reads 1 for WR_CYCLES system clocks. When the cycle ends, the write-enable latch clears.
- R7: A memory write or status write is discarded, and no busy cycle starts, if the write-enable latch was clear at the instruction or if chip select rises partway through a byte.
- R8: While busy, only 0x05 is answered. Any other instruction changes nothing, and a read returns zeros.
- R9: Instruction 0x01 takes one data byte. On a valid commit it stores bit 7 and bits 3:2 of that byte, shows them on prot_bits_o as {bit7, bit3, bit2}, and starts a busy cycle.
- R10: While hold_i is high, SCK edges are ignored and sdo_en_o is low. The transaction resumes intact once hold_i falls.
- R11: If arr_wr_en_i (for a memory write) or sr_wr_en_i (for a status write) is low when chip select rises, the commit is dropped, no busy cycle starts and the latch is kept.
- R12: sdo_en_o is low while chip select is high. Bytes that follow the first byte of a transaction are never decoded as instructions.
- R13: After reset the latch, busy flag and prot_bits_o are 0, and sdo_en_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, 0 when not enabled |
| sdo_en_o | output | 1 | Output enable for the data-out pad; low means high impedance |
| hold_i | input | 1 | Pause request from the hold logic |
| arr_wr_en_i | input | 1 | Memory commit allowed by the protection logic |
| sr_wr_en_i | input | 1 | Status commit allowed by the protection logic |
| prot_bits_o | output | 3 | Stored {protect-enable, protection bits} |

## Verification
Two things meet at the same moment. The rising edge of chip select decides a commit, while the partial-byte count and the protection enables are evaluated in that same cycle. The bench provokes this by ending transactions one, two and three bits short or exactly on a byte boundary, with each enable low or high. Each case is judged by a following status read (busy and latch bits) and a readback of the page. A second overlap arises when a status read starts right after a commit: the status snapshot must already show busy with the latch still set. An instruction that should be ignored, issued inside the same busy window, must leave the latch unchanged.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_AHI, ST_ALO, ST_RD, ST_WDATA,
    ST_SRD, ST_SWR, ST_SWR_OK, ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic cs_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sdi_o,
  output logic cs_act_o,
  output logic cs_start_o,
  output logic cs_end_o
);
  logic [STAGES:0] sck_q, sdi_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      sdi_q <= '0;
      cs_q  <= '1;
    end else begin
      sck_q <= {sck_q[STAGES-1:0], sck_i};
      sdi_q <= {sdi_q[STAGES-1:0], sdi_i};
      cs_q  <= {cs_q[STAGES-1:0], cs_ni};
    end
  end

  assign sck_rise_o = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign sdi_o      = sdi_q[STAGES-1];
  assign cs_act_o   = ~cs_q[STAGES-1];
  assign cs_start_o = ~cs_q[STAGES-1] & cs_q[STAGES];
  assign cs_end_o   = cs_q[STAGES-1] & ~cs_q[STAGES];
endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int PAGE_W = 6,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DW-1:0]         data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (we_i) begin
      vld_q[widx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[widx_i] <= wdata_i;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_ee_core.sv
module spi_ee_core
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_W     = 6,
  parameter int SYNC_STG   = 2,
  parameter int WR_CYCLES  = 625000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_en_o,
  input  logic       hold_i,
  input  logic       arr_wr_en_i,
  input  logic       sr_wr_en_i,
  output logic [2:0] prot_bits_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  initial assert (WR_CYCLES >= PAGE_BYTES);

  logic sck_rise, sck_fall, sdi_s, cs_act, cs_start, cs_end;

  spi_ee_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .sdi_i      (sdi_i),
    .cs_ni      (cs_ni),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .sdi_o      (sdi_s),
    .cs_act_o   (cs_act),
    .cs_start_o (cs_start),
    .cs_end_o   (cs_end)
  );

  ee_state_e         state_q;
  logic [2:0]        bit_cnt_q;
  logic [7:0]        rx_sr_q, tx_sr_q;
  logic              sdo_q, out_act_q, is_wr_q, wr_have_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]   pg_q;
  logic              wel_q, wpen_q;
  logic [1:0]        bp_q;
  logic [2:0]        sr_stage_q;
  logic              busy_q, do_arr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] cidx_q;

  logic              sck_r, sck_f, byte_done, busy_done;
  logic [7:0]        rx_byte, stat_byte, arr_rdata, buf_rdata;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_commit, sr_commit, buf_we, buf_clr, buf_valid, arr_we;

  assign sck_r     = sck_rise & ~hold_i & cs_act & ~cs_start;
  assign sck_f     = sck_fall & ~hold_i & cs_act & ~cs_start;
  assign rx_byte   = {rx_sr_q[6:0], sdi_s};
  assign byte_done = sck_r && (state_q != ST_IDLE) && (bit_cnt_q == 3'd7);
  assign stat_byte = {wpen_q, 3'b000, bp_q, wel_q, busy_q};
  assign rd_addr   = (state_q == ST_ALO) ? {addr_q[ADDR_W-1:8], rx_byte} : addr_q;
  assign busy_done = busy_q && (cnt_q == '0);

  // commit decided on the chip-select rising edge, only on a byte boundary
  assign wr_commit = cs_end && (state_q == ST_WDATA) && wr_have_q &&
                     (bit_cnt_q == 3'd0) && arr_wr_en_i;
  assign sr_commit = cs_end && (state_q == ST_SWR_OK) &&
                     (bit_cnt_q == 3'd0) && sr_wr_en_i;

  assign buf_we  = byte_done && (state_q == ST_WDATA);
  assign buf_clr = byte_done && (state_q == ST_OPC) && !busy_q && (rx_byte == OP_MEM_WR);

  spi_ee_pagebuf #(.PAGE_W(PAGE_W), .DW(8)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (buf_clr),
    .we_i     (buf_we),
    .widx_i   (addr_q[PAGE_W-1:0]),
    .wdata_i  (rx_byte),
    .ridx_i   (cidx_q),
    .rdata_o  (buf_rdata),
    .rvalid_o (buf_valid)
  );

  assign arr_we = busy_q & do_arr_q & buf_valid;

  spi_ee_array #(.AW(ADDR_W), .DW(8)) u_arr (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .waddr_i ({pg_q, cidx_q}),
    .wdata_i (buf_rdata),
    .raddr_i (rd_addr),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      sdo_q      <= 1'b0;
      out_act_q  <= 1'b0;
      is_wr_q    <= 1'b0;
      wr_have_q  <= 1'b0;
      addr_q     <= '0;
      pg_q       <= '0;
      wel_q      <= 1'b0;
      wpen_q     <= 1'b0;
      bp_q       <= '0;
      sr_stage_q <= '0;
    end else begin
      if (cs_start) begin
        state_q   <= ST_OPC;
        bit_cnt_q <= '0;
        out_act_q <= 1'b0;
        wr_have_q <= 1'b0;
        sdo_q     <= 1'b0;
      end else if (cs_end) begin
        state_q   <= ST_IDLE;
        out_act_q <= 1'b0;
        if (sr_commit) {wpen_q, bp_q} <= sr_stage_q;
      end else if (sck_f && out_act_q) begin
        sdo_q   <= tx_sr_q[7];
        tx_sr_q <= {tx_sr_q[6:0], 1'b0};
      end else if (sck_r && state_q != ST_IDLE) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        rx_sr_q   <= rx_byte;
        if (bit_cnt_q == 3'd7) begin
          unique case (state_q)
            ST_OPC: begin
              if (busy_q) begin
                // only status reads are answered during an internal write
                if (rx_byte == OP_STAT_RD) begin
                  state_q   <= ST_SRD;
                  tx_sr_q   <= stat_byte;
                  out_act_q <= 1'b1;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else begin
                case (rx_byte)
                  OP_WEL_SET: begin wel_q <= 1'b1; state_q <= ST_SKIP; end
                  OP_WEL_CLR: begin wel_q <= 1'b0; state_q <= ST_SKIP; end
                  OP_STAT_RD: begin
                    state_q   <= ST_SRD;
                    tx_sr_q   <= stat_byte;
                    out_act_q <= 1'b1;
                  end
                  OP_STAT_WR: state_q <= wel_q ? ST_SWR : ST_SKIP;
                  OP_MEM_RD: begin state_q <= ST_AHI; is_wr_q <= 1'b0; end
                  OP_MEM_WR: begin
                    state_q <= wel_q ? ST_AHI : ST_SKIP;
                    is_wr_q <= 1'b1;
                  end
                  default: state_q <= ST_SKIP;
                endcase
              end
            end
            ST_AHI: begin
              addr_q[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
              state_q <= ST_ALO;
            end
            ST_ALO: begin
              if (is_wr_q) begin
                addr_q  <= rd_addr;
                pg_q    <= rd_addr[ADDR_W-1:PAGE_W];
                state_q <= ST_WDATA;
              end else begin
                tx_sr_q   <= arr_rdata;
                out_act_q <= 1'b1;
                addr_q    <= rd_addr + ADDR_W'(1);
                state_q   <= ST_RD;
              end
            end
            ST_RD: begin
              tx_sr_q <= arr_rdata;
              addr_q  <= addr_q + ADDR_W'(1);
            end
            ST_WDATA: begin
              addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
              wr_have_q <= 1'b1;
            end
            ST_SRD: tx_sr_q <= stat_byte;
            ST_SWR: begin
              sr_stage_q <= {rx_byte[7], rx_byte[3:2]};
              state_q    <= ST_SWR_OK;
            end
            default: ;
          endcase
        end
      end
      if (busy_done) wel_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      do_arr_q <= 1'b0;
      cnt_q    <= '0;
      cidx_q   <= '0;
    end else if (wr_commit || sr_commit) begin
      busy_q   <= 1'b1;
      do_arr_q <= wr_commit;
      cnt_q    <= CNT_W'(WR_CYCLES - 1);
      cidx_q   <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == '0) busy_q <= 1'b0;
      if (do_arr_q) begin
        cidx_q <= cidx_q + PAGE_W'(1);
        if (cidx_q == PAGE_W'(PAGE_BYTES - 1)) do_arr_q <= 1'b0;
      end
    end
  end

  assign sdo_en_o    = cs_act & ~hold_i;
  assign sdo_o       = sdo_en_o & sdo_q;
  assign prot_bits_o = {wpen_q, bp_q};

  // busy window length check
  logic [CNT_W:0] chk_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_len_q <= '0;
    else if (!busy_q) chk_len_q <= '0;
    else              chk_len_q <= chk_len_q + (CNT_W+1)'(1);
  end

  AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> chk_len_q == (CNT_W+1)'(WR_CYCLES)); // R6
  AST_WEL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !wel_q); // R6
  AST_BUSY_FROM_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cs_end)); // R5
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(wel_q)); // R7
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !cs_start) |=> $stable(bit_cnt_q)); // R10
endmodule

// File: tb/spi_ee_core_tb_top.sv
module spi_ee_core_tb_top;
  localparam int WRC  = 1200;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold = 1'b0;
  logic arr_en = 1'b1, sr_en = 1'b1;
  logic sdo, sdo_en;
  logic [2:0] prot;

  always #4 clk = ~clk;

  spi_ee_core #(.WR_CYCLES(WRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .hold_i(hold), .arr_wr_en_i(arr_en),
    .sr_wr_en_i(sr_en), .prot_bits_o(prot)
  );

  int n_cmp = 0, n_bad = 0, mode = 0;
  bit done = 1'b0;
  logic [7:0] mdl [8192];
  bit         kn  [8192];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 13) + (s * 29) + 5);
  endfunction

  task automatic cs_on();
    sck = (mode == 3);
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_off();
    if (mode == 0) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1;
    tick(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input int hold_bit = -1);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; sdi = tx[i];
      tick(HALF);
      rx[i] = sdo;
      if (i == hold_bit) begin
        hold = 1'b1; tick(2);
        for (int k = 0; k < 2; k++) begin sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF); end
        chk("R10 hold disables output", sdo_en, 0);
        hold = 1'b0; tick(2);
      end
      sck = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; sdi = tx[i]; tick(HALF);
      sck = 1'b1; tick(HALF);
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_on(); xbyte(op, r); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_on(); xbyte(8'h05, r); xbyte(8'h00, s); cs_off();
  endtask

  task automatic stat_chk(input string req, input int exp);
    logic [7:0] s;
    rdsr(s);
    chk(req, s, exp);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    cs_on(); xbyte(8'h01, r); xbyte(v, r); cs_off();
  endtask

  task automatic mem_wr(input int addr, input int n, input int seed, input bit upd, input int xhi);
    logic [7:0] r;
    cs_on();
    xbyte(8'h02, r);
    xbyte(8'((addr >> 8) & 31) | 8'(xhi << 5), r);
    xbyte(8'(addr), r);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (addr & ~63) | ((addr + k) & 63);
      xbyte(pat(a, seed), r);
      if (upd) begin mdl[a] = pat(a, seed); kn[a] = 1'b1; end
    end
    cs_off();
  endtask

  task automatic mem_rd(input string req, input int addr, input int n, input int xhi,
                        input int hold_k = -1);
    logic [7:0] r;
    cs_on();
    xbyte(8'h03, r);
    xbyte(8'((addr >> 8) & 31) | 8'(xhi << 5), r);
    xbyte(8'(addr), r);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (addr + k) & 8191;
      xbyte(8'h00, r, (k == hold_k) ? 4 : -1);
      if (kn[a]) chk(req, r, mdl[a]);
    end
    cs_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r;
    for (int i = 0; i < 8192; i++) kn[i] = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);

    // R13 reset state
    chk("R13 sdo_en after reset", sdo_en, 0);
    chk("R13 prot after reset", prot, 0);
    stat_chk("R13 status after reset", 8'h00);

    // R2 / R1 latch control in both framings
    mode = 0; cmd(8'h06); stat_chk("R2 set latch mode0", 8'h02);
    mode = 3; stat_chk("R1 status mode3", 8'h02);
    cmd(8'h04); stat_chk("R2 clear latch mode3", 8'h00);

    // R7 write without latch: no busy
    mode = 0; mem_wr(16'h0040, 4, 3, 1'b0, 0);
    stat_chk("R7 no latch no busy", 8'h00);

    // page sweep, R5 / R6
    for (int pi = 0; pi < 5; pi++) begin
      int pg;
      pg = (pi == 3) ? 127 : ((pi == 4) ? 64 : pi);
      mode = (pi % 2) ? 3 : 0;
      cmd(8'h06);
      mem_wr(pg * 64, 64, pi, 1'b1, pi % 8);
      stat_chk("R6 busy after commit", 8'h03);
      tick(WRC + 20);
      stat_chk("R6 latch cleared after cycle", 8'h00);
    end

    // R4 / R1 readback
    mode = 0; mem_rd("R4 read page0-2 mode0", 16'h0000, 192, 7);
    mode = 3; mem_rd("R1 read page127 mode3", 16'h1FC0, 64, 2);
    mode = 0; mem_rd("R4 read wrap 1FFF->0", 16'h1FFE, 4, 5);
    mode = 3; mem_rd("R4 read page64", 16'h1000, 64, 0);

    // R5 page wrap inside page 1
    mode = 0; cmd(8'h06);
    mem_wr(16'h007C, 6, 9, 1'b1, 0);
    tick(WRC + 20);
    mem_rd("R5 page wrap write", 16'h0040, 64, 0);

    // R7 chip select rises mid-byte
    cmd(8'h06);
    cs_on(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h80, r);
    xbyte(8'h5A, r); xbits(8'hFF, 3); cs_off();
    stat_chk("R7 partial byte no busy", 8'h02);
    mem_rd("R7 partial byte array kept", 16'h0080, 2, 0);

    // R8 while busy
    mem_wr(16'h1000, 2, 11, 1'b1, 0);
    cmd(8'h04);
    stat_chk("R8 clear ignored while busy", 8'h03);
    cs_on(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r); cs_off();
    chk("R8 read ignored while busy", r, 8'h00);
    tick(WRC + 20);
    stat_chk("R8 after busy", 8'h00);
    mem_rd("R5 two-byte write committed", 16'h1000, 3, 0);

    // R9 status write
    mode = 3; cmd(8'h06); wrsr(8'hFF);
    chk("R9 prot bits stored", prot, 3'b111);
    stat_chk("R9 status busy with protection", 8'h8F);
    tick(WRC + 20);
    stat_chk("R9 status after cycle", 8'h8C);
    cmd(8'h06); wrsr(8'h00); tick(WRC + 20);
    chk("R9 prot bits cleared", prot, 3'b000);

    // R11 commit enables
    arr_en = 1'b0; cmd(8'h06); mem_wr(16'h0080, 2, 20, 1'b0, 0); arr_en = 1'b1;
    stat_chk("R11 array commit dropped", 8'h02);
    mem_rd("R11 array unchanged", 16'h0080, 2, 0);
    sr_en = 1'b0; wrsr(8'h0C); sr_en = 1'b1;
    chk("R11 status commit dropped", prot, 3'b000);
    stat_chk("R11 latch kept", 8'h02);
    cmd(8'h04);

    // R10 hold in the middle of a read
    mode = 0; mem_rd("R10 read across hold", 16'h0040, 3, 0, 1);

    // R12 idle output and no re-decode inside a transaction
    chk("R12 output off while deselected", sdo_en, 0);
    cs_on(); xbyte(8'h05, r); xbyte(8'h06, s); chk("R3 status repeat 1", s, 8'h00);
    xbyte(8'h00, s); chk("R3 status repeat 2", s, 8'h00); cs_off();
    stat_chk("R12 second byte not decoded", 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule